// File: doc/BRIEF.md
# Coprocessor Transfer Address Sequencer

This unit sits on the processor side of a coprocessor load/store instruction. It is given the decoded instruction fields: a base register value, an 8-bit unsigned word count with a separate direction bit, a pre/post-index select and a write-back request. From these it forms the first memory address of the transfer. It then presents one word address per beat on a request/acknowledge memory port.

The coprocessor alone decides how long the transfer is. It marks the final word with a "last" flag, and the sequencer keeps stepping upward by one word for each acknowledged beat until that flag arrives. When the transfer ends, whether normally or through a memory abort, the updated base value is offered on its own output with a one-cycle strobe, but only if write-back applies.

A start address outside the 26-bit address space raises a one-cycle address exception instead of starting the transfer. Later beats are not checked, and they wrap silently inside the 26-bit space.

Top module: `cpx_xfer_seq`

## Requirements
- R1: In pre-index mode (`pre_i`=1) the first beat address is `base_i` plus `ofs_i`×4 when `up_i`=1, or minus `ofs_i`×4 when `up_i`=0. The first beat is presented (`mem_req_o`=1) in the cycle after `start_i` is sampled.
- R2: In post-index mode (`pre_i`=0) the first beat address is `base_i`, with the offset not applied.
- R3: The write-back value is `base_i` ± `ofs_i`×4, using the full 32-bit result. It is strobed on `wb_valid_o` for exactly one cycle, in the cycle after the transfer ends. The strobe occurs in post-index mode always, and in pre-index mode only when `wb_req_i`=1.
- R4: Each beat acknowledged without last or abort is followed by a beat at the address plus 4. While `mem_ack_i` is low, the request and the address are held unchanged.
- R5: A beat acknowledged with `cop_last_i`=1 ends the transfer, and `mem_req_o` is low in the next cycle.
- R6: If any of bits 31..26 of the computed start address is set, `addr_exc_o` is high for exactly one cycle, in the cycle after `start_i`. No beat is requested and no write-back is strobed.
- R7: Beat addresses after the first wrap within bits 25..0: the beat after 0x03FFFFFC is 0x00000000, and no exception is raised.
- R8: `mem_abort_i` high during a requested beat ends the transfer, and this takes priority over ack and last. In the next cycle `abort_o` is high for one cycle, `mem_req_o` is low, and the write-back strobe follows the rule of R3.
- R9: Bits 1..0 of every presented beat address are zero, even when `base_i` is not word aligned.
- R10: `start_i` is ignored while `busy_o` is high: the running transfer's addresses are unaffected.
- R11: After reset, `mem_req_o`, `addr_exc_o`, `abort_o`, `wb_valid_o` and `busy_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Instruction issue, sampled only when idle |
| base_i | input | 32 | Base register value |
| ofs_i | input | 8 | Offset as a word count |
| up_i | input | 1 | 1 adds the offset, 0 subtracts it |
| pre_i | input | 1 | 1 pre-index, 0 post-index |
| wb_req_i | input | 1 | Write-back requested (pre-index only) |
| cop_last_i | input | 1 | Coprocessor marks the current beat as final |
| mem_ack_i | input | 1 | Memory accepts the current beat |
| mem_abort_i | input | 1 | Memory aborts the current beat |
| mem_req_o | output | 1 | Beat request |
| mem_addr_o | output | 32 | Beat word address |
| busy_o | output | 1 | A transfer is in progress |
| addr_exc_o | output | 1 | One-cycle address exception pulse |
| abort_o | output | 1 | One-cycle abort pulse |
| wb_valid_o | output | 1 | One-cycle write-back strobe |
| wb_data_o | output | 32 | New base register value |

## Verification
A corrupted held address or wrong beat counter would show on `mem_addr_o` at the very next acknowledged beat, as a step other than +4. It would also show as a change while acknowledge is low. A stuck state machine shows within one cycle of a final or aborted beat, as a request that stays high or a missing strobe. A wrong exception decision shows in the cycle after issue, either as a request where a pulse was due or as a pulse where a request was due. Wrong write-back state appears only on the strobe cycle, so every scenario checks `wb_valid_o` and `wb_data_o` there and also one cycle later.

// File: rtl/cpx_seq_pkg.sv
package cpx_seq_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        seq_state_e  state;
        logic [31:0] addr;
        logic        wb_en;
        logic [31:0] wb_val;
        logic        exc;
        logic        abt;
        logic        wbv;
    } seq_regs_t;

endpackage

// File: rtl/cpx_ea_calc.sv
module cpx_ea_calc #(
    parameter int ADDR_W  = 32,
    parameter int OFS_W   = 8,
    parameter int SPACE_W = 26
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic              up_i,
    input  logic              pre_i,
    input  logic              wb_req_i,
    output logic [ADDR_W-1:0] start_addr_o,
    output logic              illegal_o,
    output logic              wb_en_o,
    output logic [ADDR_W-1:0] wb_val_o
);
    localparam int PAD_W = ADDR_W - OFS_W - 2;

    logic [ADDR_W-1:0] byte_ofs;
    logic [ADDR_W-1:0] moved;
    logic [ADDR_W-1:0] start_raw;

    always_comb begin
        // word count scaled to bytes
        byte_ofs     = {{PAD_W{1'b0}}, ofs_i, 2'b00};
        moved        = up_i ? (base_i + byte_ofs) : (base_i - byte_ofs);
        start_raw    = pre_i ? moved : base_i;
        start_addr_o = start_raw & ~ADDR_W'(3);
        illegal_o    = |start_raw[ADDR_W-1:SPACE_W];
        wb_en_o      = !pre_i || wb_req_i;
        wb_val_o     = moved;
    end
endmodule

// File: rtl/cpx_beat_fsm.sv
module cpx_beat_fsm
    import cpx_seq_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int SPACE_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              illegal_i,
    input  logic              wb_en_i,
    input  logic [ADDR_W-1:0] wb_val_i,
    input  logic              cop_last_i,
    input  logic              mem_ack_i,
    input  logic              mem_abort_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              busy_o,
    output logic              addr_exc_o,
    output logic              abort_o,
    output logic              wb_valid_o,
    output logic [ADDR_W-1:0] wb_data_o
);
    localparam int HI_W = ADDR_W - SPACE_W;

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.exc = 1'b0;
        r_d.abt = 1'b0;
        r_d.wbv = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    if (illegal_i) begin
                        r_d.exc = 1'b1;
                    end else begin
                        r_d.state  = ST_RUN;
                        r_d.addr   = start_addr_i;
                        r_d.wb_en  = wb_en_i;
                        r_d.wb_val = wb_val_i;
                    end
                end
            end
            ST_RUN: begin
                if (mem_abort_i) begin
                    r_d.state = ST_IDLE;
                    r_d.abt   = 1'b1;
                    r_d.wbv   = r_q.wb_en;
                end else if (mem_ack_i && cop_last_i) begin
                    r_d.state = ST_IDLE;
                    r_d.wbv   = r_q.wb_en;
                end else if (mem_ack_i) begin
                    r_d.addr = {{HI_W{1'b0}},
                                r_q.addr[SPACE_W-1:0] + SPACE_W'(4)};
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, addr: '0, wb_en: 1'b0, wb_val: '0,
                     exc: 1'b0, abt: 1'b0, wbv: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_req_o  = (r_q.state == ST_RUN);
    assign mem_addr_o = r_q.addr;
    assign busy_o     = (r_q.state == ST_RUN);
    assign addr_exc_o = r_q.exc;
    assign abort_o    = r_q.abt;
    assign wb_valid_o = r_q.wbv;
    assign wb_data_o  = r_q.wb_val;

    // R4
    step_four_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_ack_i && !cop_last_i && !mem_abort_i) |=>
        (mem_req_o && mem_addr_o[SPACE_W-1:0] ==
         $past(mem_addr_o[SPACE_W-1:0]) + SPACE_W'(4)));

    // R4
    hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i && !mem_abort_i) |=>
        (mem_req_o && $stable(mem_addr_o)));

    // R5
    last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_ack_i && cop_last_i) |=> !mem_req_o);

    // R8
    abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_abort_i) |=> (abort_o && !mem_req_o));

    // R8
    abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> !abort_o);

    // R6
    exc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_exc_o |-> (!mem_req_o && !wb_valid_o && !abort_o));

    // R9
    aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_addr_o[1:0] == 2'b00 && mem_addr_o[ADDR_W-1:SPACE_W] == '0));
endmodule

// File: rtl/cpx_xfer_seq.sv
module cpx_xfer_seq #(
    parameter int ADDR_W  = 32,
    parameter int OFS_W   = 8,
    parameter int SPACE_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic              up_i,
    input  logic              pre_i,
    input  logic              wb_req_i,
    input  logic              cop_last_i,
    input  logic              mem_ack_i,
    input  logic              mem_abort_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              busy_o,
    output logic              addr_exc_o,
    output logic              abort_o,
    output logic              wb_valid_o,
    output logic [ADDR_W-1:0] wb_data_o
);
    logic [ADDR_W-1:0] start_addr;
    logic              illegal;
    logic              wb_en;
    logic [ADDR_W-1:0] wb_val;

    cpx_ea_calc #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .SPACE_W(SPACE_W)) u_ea (
        .base_i       (base_i),
        .ofs_i        (ofs_i),
        .up_i         (up_i),
        .pre_i        (pre_i),
        .wb_req_i     (wb_req_i),
        .start_addr_o (start_addr),
        .illegal_o    (illegal),
        .wb_en_o      (wb_en),
        .wb_val_o     (wb_val)
    );

    cpx_beat_fsm #(.ADDR_W(ADDR_W), .SPACE_W(SPACE_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .start_addr_i (start_addr),
        .illegal_i    (illegal),
        .wb_en_i      (wb_en),
        .wb_val_i     (wb_val),
        .cop_last_i   (cop_last_i),
        .mem_ack_i    (mem_ack_i),
        .mem_abort_i  (mem_abort_i),
        .mem_req_o    (mem_req_o),
        .mem_addr_o   (mem_addr_o),
        .busy_o       (busy_o),
        .addr_exc_o   (addr_exc_o),
        .abort_o      (abort_o),
        .wb_valid_o   (wb_valid_o),
        .wb_data_o    (wb_data_o)
    );

    // R6
    pulses_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({addr_exc_o, abort_o}));

    // R10
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !mem_ack_i && !mem_abort_i) |=> $stable(mem_addr_o));
endmodule

// File: tb/tb_cpx_xfer_seq.sv
`timescale 1ns/1ps
module tb_cpx_xfer_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] base_i = '0;
    logic [7:0]  ofs_i = '0;
    logic        up_i = 1'b0, pre_i = 1'b0, wb_req_i = 1'b0;
    logic        cop_last_i = 1'b0, mem_ack_i = 1'b0, mem_abort_i = 1'b0;
    logic        mem_req_o, busy_o, addr_exc_o, abort_o, wb_valid_o;
    logic [31:0] mem_addr_o, wb_data_o;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    cpx_xfer_seq dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
        .ofs_i(ofs_i), .up_i(up_i), .pre_i(pre_i), .wb_req_i(wb_req_i),
        .cop_last_i(cop_last_i), .mem_ack_i(mem_ack_i), .mem_abort_i(mem_abort_i),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .busy_o(busy_o),
        .addr_exc_o(addr_exc_o), .abort_o(abort_o), .wb_valid_o(wb_valid_o),
        .wb_data_o(wb_data_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] b, input logic [7:0] o,
                         input logic u, input logic p, input logic w);
        @(negedge clk);
        start_i = 1'b1; base_i = b; ofs_i = o; up_i = u; pre_i = p; wb_req_i = w;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // present check of the current beat, then acknowledge it
    task automatic beat(input logic [31:0] exp, input logic last, input string tag);
        chk(mem_req_o === 1'b1, {tag, " req"}, 32'(mem_req_o), 32'd1);
        chk(mem_addr_o === exp, {tag, " addr"}, mem_addr_o, exp);
        mem_ack_i = 1'b1; cop_last_i = last;
        @(negedge clk);
        mem_ack_i = 1'b0; cop_last_i = 1'b0;
    endtask

    task automatic ending(input logic exp_wb, input logic [31:0] exp_val, input string tag);
        chk(mem_req_o === 1'b0, {tag, " req low"}, 32'(mem_req_o), 32'd0);
        chk(wb_valid_o === exp_wb, {tag, " wb strobe"}, 32'(wb_valid_o), 32'(exp_wb));
        if (exp_wb) chk(wb_data_o === exp_val, {tag, " wb value"}, wb_data_o, exp_val);
        @(negedge clk);
        chk(wb_valid_o === 1'b0, {tag, " wb one cycle"}, 32'(wb_valid_o), 32'd0);
    endtask

    task automatic t_reset();
        chk(mem_req_o === 1'b0, "R11 req", 32'(mem_req_o), 0);
        chk(busy_o === 1'b0, "R11 busy", 32'(busy_o), 0);
        chk({addr_exc_o, abort_o, wb_valid_o} === 3'b000, "R11 pulses",
            32'({addr_exc_o, abort_o, wb_valid_o}), 0);
    endtask

    task automatic t_pre_up_wb();   // R1 R3 R4 R5
        issue(32'h0000_1000, 8'd8, 1'b1, 1'b1, 1'b1);
        beat(32'h0000_1020, 1'b0, "R1 pre up first");
        beat(32'h0000_1024, 1'b0, "R4 step");
        beat(32'h0000_1028, 1'b1, "R4 step last");
        ending(1'b1, 32'h0000_1020, "R3 R5 pre wb");
    endtask

    task automatic t_pre_down_nowb();   // R1 R3
        issue(32'h0000_2000, 8'd255, 1'b0, 1'b1, 1'b0);
        beat(32'h0000_1C04, 1'b1, "R1 pre down max");
        ending(1'b0, 32'h0, "R3 pre no wb");
    endtask

    task automatic t_post();   // R2 R3
        issue(32'h0000_3000, 8'd4, 1'b1, 1'b0, 1'b0);
        beat(32'h0000_3000, 1'b0, "R2 post first");
        beat(32'h0000_3004, 1'b0, "R2 post b2");
        beat(32'h0000_3008, 1'b0, "R2 post b3");
        beat(32'h0000_300C, 1'b1, "R2 post b4");
        ending(1'b1, 32'h0000_3010, "R3 post always wb");
    endtask

    task automatic t_stall();   // R4
        issue(32'h0000_4000, 8'd0, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        @(negedge clk);
        beat(32'h0000_4000, 1'b0, "R4 held while no ack");
        beat(32'h0000_4004, 1'b1, "R4 after stall");
        ending(1'b1, 32'h0000_4000, "R3 post zero ofs");
    endtask

    task automatic t_exc(input logic [31:0] b, input logic [7:0] o, input logic u,
                         input string tag);   // R6
        issue(b, o, u, 1'b1, 1'b1);
        chk(addr_exc_o === 1'b1, {tag, " exc pulse"}, 32'(addr_exc_o), 1);
        chk(mem_req_o === 1'b0, {tag, " no req"}, 32'(mem_req_o), 0);
        chk(wb_valid_o === 1'b0, {tag, " no wb"}, 32'(wb_valid_o), 0);
        @(negedge clk);
        chk(addr_exc_o === 1'b0, {tag, " exc one cycle"}, 32'(addr_exc_o), 0);
        chk(busy_o === 1'b0, {tag, " idle"}, 32'(busy_o), 0);
    endtask

    task automatic t_wrap();   // R7
        issue(32'h03FF_FFF8, 8'd0, 1'b1, 1'b0, 1'b0);
        chk(addr_exc_o === 1'b0, "R7 legal start", 32'(addr_exc_o), 0);
        beat(32'h03FF_FFF8, 1'b0, "R7 b1");
        beat(32'h03FF_FFFC, 1'b0, "R7 b2");
        chk(addr_exc_o === 1'b0, "R7 no exc on wrap", 32'(addr_exc_o), 0);
        beat(32'h0000_0000, 1'b1, "R7 wrapped");
        ending(1'b1, 32'h03FF_FFF8, "R7 end");
    endtask

    task automatic t_abort(input logic w, input logic p, input string tag);   // R8
        issue(32'h0000_0100, 8'd2, 1'b1, p, w);
        beat(p ? 32'h0000_0108 : 32'h0000_0100, 1'b0, {tag, " b1"});
        mem_abort_i = 1'b1; mem_ack_i = 1'b1; cop_last_i = 1'b1;
        @(negedge clk);
        mem_abort_i = 1'b0; mem_ack_i = 1'b0; cop_last_i = 1'b0;
        chk(abort_o === 1'b1, {tag, " abort pulse"}, 32'(abort_o), 1);
        chk(mem_req_o === 1'b0, {tag, " req low"}, 32'(mem_req_o), 0);
        chk(wb_valid_o === (w | !p), {tag, " wb strobe"}, 32'(wb_valid_o), 32'(w | !p));
        if (w | !p) chk(wb_data_o === 32'h108, {tag, " wb value"}, wb_data_o, 32'h108);
        @(negedge clk);
        chk(abort_o === 1'b0, {tag, " abort one cycle"}, 32'(abort_o), 0);
    endtask

    task automatic t_unaligned();   // R9
        issue(32'h0000_5003, 8'd1, 1'b1, 1'b1, 1'b1);
        beat(32'h0000_5004, 1'b0, "R9 pre aligned");
        beat(32'h0000_5008, 1'b1, "R9 next aligned");
        ending(1'b1, 32'h0000_5007, "R9 wb raw");
    endtask

    task automatic t_busy_ignore();   // R10
        issue(32'h0000_6000, 8'd0, 1'b1, 1'b0, 1'b0);
        start_i = 1'b1; base_i = 32'h0000_7700; pre_i = 1'b1; ofs_i = 8'd3;
        @(negedge clk);
        start_i = 1'b0;
        beat(32'h0000_6000, 1'b0, "R10 unaffected");
        beat(32'h0000_6004, 1'b1, "R10 continues");
        ending(1'b1, 32'h0000_6000, "R10 wb kept");
    endtask

    initial begin
        #(5.0 * 100000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pre_up_wb();
        t_pre_down_nowb();
        t_post();
        t_stall();
        t_exc(32'h0400_0000, 8'd0, 1'b1, "R6 bit26");
        t_exc(32'h0000_0000, 8'd1, 1'b0, "R6 below zero");
        t_exc(32'h03FF_FFFC, 8'd1, 1'b1, "R6 offset crosses");
        t_wrap();
        t_abort(1'b1, 1'b1, "R8 pre wb");
        t_abort(1'b0, 1'b1, "R8 pre no wb");
        t_abort(1'b0, 1'b0, "R8 post");
        t_unaligned();
        t_busy_ignore();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule